// File: doc/BRIEF.md
# Linear CCD Timing Generator

This block produces the digital drive waveforms for a linear CCD image sensor. It generates two complementary shift clocks, a reset-gate pulse and a transfer-gate pulse, and counts every interval in master-clock cycles. Each line is started by a one-cycle request. The line then runs through four stages in order: a guard interval, the transfer pulse, a second guard interval, and finally pixel clocking.

Pixel clocking runs through three groups in turn: leading dummy pixels, optical-black reference pixels, and active pixels. A two-bit class output tags every pixel period with its group, so downstream logic can pick out the black-level samples. Each output has its own enable and a polarity control. Every setting arrives on parallel inputs and is captured when a line is accepted. Changes made during a line therefore apply from the next line on.

Top module: `ccd_timing_gen`

## Requirements
- R1: A line request (`lineStart` high at a rising edge while idle) starts a line. Let state cycle t=0 be the cycle after that edge. The line runs a guard interval of G cycles, then the transfer stage of W cycles, then a second guard of G cycles, then N pixel periods of P cycles each, and then returns to idle. Every output shows the stage of cycle t one clock later, in cycle t+1.
- R2: The transfer output is active throughout the transfer stage and at no other time. W = max(`trWidth`, 20).
- R3: Both guard intervals last G = max(`guardLen`, 20) cycles. During the guards and the transfer stage, the raw phase-1 clock is low and the raw phase-2 clock is high.
- R4: During pixel k (counting from 0), the raw phase-1 clock is high when k is even and low when k is odd. The raw phase-2 clock is always the complement of the raw phase-1 clock. In idle, raw phase-1 is low and raw phase-2 is high.
- R5: The raw reset-gate pulse is high for exactly the first cycle of each pixel period. P = max(`pixPeriod`, 4).
- R6: `pixClass` encodes the pixel group: 0 = no pixel, 1 = dummy, 2 = optical black, 3 = active. A line has D = max(`dummyReg`,1) - 1 dummy pixels, then B = max(`obReg`,1) optical-black pixels, then `activeCnt` active pixels, so N = D + B + `activeCnt`.
- R7: `enMask` bits are assigned as follows: bit 0 phase-1, bit 1 phase-2, bit 2 reset gate, bit 3 transfer. An output whose bit is 0 is held at raw level 0, with polarity still applied.
- R8: `invMask` bits are assigned as follows: bit 0 inverts both shift clocks, bit 1 inverts the reset gate, bit 2 inverts the transfer gate. Each pin equals (enable AND raw) XOR invert.
- R9: All setting inputs (`enMask`, `invMask` and the timing and count inputs) are captured only when a line is accepted. A request or a setting change during a running line has no effect on that line.
- R10: While synchronous reset `rst` is high, the sequencer returns to idle and the settings are loaded from the inputs. On the edge after reset, the outputs take their idle levels under those settings, with `pixClass` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| lineStart | input | 1 | Line request, sampled when idle |
| enMask | input | 4 | Output enables: phase-1, phase-2, reset gate, transfer |
| invMask | input | 3 | Polarity inverts: shift clocks, reset gate, transfer |
| trWidth | input | 8 | Transfer pulse width in cycles (minimum 20) |
| guardLen | input | 8 | Guard interval in cycles (minimum 20) |
| pixPeriod | input | 6 | Pixel period in cycles (minimum 4) |
| dummyReg | input | 6 | Dummy pixel count plus one |
| obReg | input | 6 | Optical-black pixel count (minimum 1) |
| activeCnt | input | 10 | Active pixel count |
| phi1 | output | 1 | Phase-1 shift clock |
| phi2 | output | 1 | Phase-2 shift clock |
| rsOut | output | 1 | Reset-gate pulse |
| trOut | output | 1 | Transfer-gate pulse |
| pixClass | output | 2 | Pixel group of the current period |

## Verification
At the first cycle of every pixel period, three things change together: the reset-gate pulse fires, both shift clocks change level, and, at a group boundary, the class output changes. The bench provokes this with the shortest legal pixel period and with small group sizes, so group boundaries come every few periods. On each line it compares all five outputs against an arithmetic model in every cycle. A second coincidence is a line request arriving in the same cycle as a change of every setting during a running line. The bench judges this by confirming that the running line is unchanged and that the new settings appear only on the following line.

// File: rtl/ccd_timing_pkg.sv
package ccd_timing_pkg;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_DUMMY  = 2'd1,
    CLS_OB     = 2'd2,
    CLS_ACTIVE = 2'd3
  } pix_class_e;

  // strobes from sequencer to output datapath
  typedef struct packed {
    logic       loadCfg;  // line accepted: capture enables and polarity
    logic       trOn;     // transfer stage
    logic       rsOn;     // first cycle of a pixel period
    logic       phiHigh;  // raw phase-1 level
    pix_class_e cls;      // group of current pixel
  } strobe_t;

endpackage

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_timing_pkg::*;
#(
  parameter int TIME_W  = 8,
  parameter int PER_W   = 6,
  parameter int DUM_W   = 6,
  parameter int OB_W    = 6,
  parameter int ACT_W   = 10,
  parameter int MIN_TR  = 20,
  parameter int MIN_GRD = 20,
  parameter int MIN_PER = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lineStart,
  input  logic [TIME_W-1:0] trWidth,
  input  logic [TIME_W-1:0] guardLen,
  input  logic [PER_W-1:0]  pixPeriod,
  input  logic [DUM_W-1:0]  dummyReg,
  input  logic [OB_W-1:0]   obReg,
  input  logic [ACT_W-1:0]  activeCnt,
  output strobe_t           strobes
);

  localparam int CNT_W  = (TIME_W > PER_W) ? TIME_W : PER_W;
  localparam int PIXN_W = $clog2((1 << DUM_W) + (1 << OB_W) + (1 << ACT_W));

  typedef enum logic [2:0] {
    ST_IDLE, ST_GUARD_A, ST_TRANSFER, ST_GUARD_B, ST_PIXELS
  } seq_state_e;

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [PIXN_W-1:0] pixIdx;

  // captured settings
  logic [CNT_W-1:0]  guardS, trS, perS;
  logic [PIXN_W-1:0] dumEndS, obEndS, pixTotalS;

  // clamped live settings
  logic [CNT_W-1:0]  guardEff, trEff, perEff;
  logic [PIXN_W-1:0] dumEff, obEff, dumEndEff, obEndEff, totEff;

  always_comb begin
    guardEff = CNT_W'(guardLen);
    if (guardEff < CNT_W'(MIN_GRD)) guardEff = CNT_W'(MIN_GRD);
    trEff = CNT_W'(trWidth);
    if (trEff < CNT_W'(MIN_TR)) trEff = CNT_W'(MIN_TR);
    perEff = CNT_W'(pixPeriod);
    if (perEff < CNT_W'(MIN_PER)) perEff = CNT_W'(MIN_PER);
    dumEff = PIXN_W'(dummyReg);
    if (dumEff == '0) dumEff = PIXN_W'(1);
    obEff = PIXN_W'(obReg);
    if (obEff == '0) obEff = PIXN_W'(1);
    dumEndEff = dumEff - PIXN_W'(1);
    obEndEff  = dumEndEff + obEff;
    totEff    = obEndEff + PIXN_W'(activeCnt);
  end

  logic accept;
  assign accept = (state == ST_IDLE) && lineStart;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pixIdx    <= '0;
      guardS    <= CNT_W'(MIN_GRD);
      trS       <= CNT_W'(MIN_TR);
      perS      <= CNT_W'(MIN_PER);
      dumEndS   <= '0;
      obEndS    <= PIXN_W'(1);
      pixTotalS <= PIXN_W'(1);
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt    <= '0;
          pixIdx <= '0;
          if (accept) begin
            guardS    <= guardEff;
            trS       <= trEff;
            perS      <= perEff;
            dumEndS   <= dumEndEff;
            obEndS    <= obEndEff;
            pixTotalS <= totEff;
            state     <= ST_GUARD_A;
          end
        end
        ST_GUARD_A: begin
          if (cnt == guardS - CNT_W'(1)) begin
            cnt   <= '0;
            state <= ST_TRANSFER;
          end else cnt <= cnt + CNT_W'(1);
        end
        ST_TRANSFER: begin
          if (cnt == trS - CNT_W'(1)) begin
            cnt   <= '0;
            state <= ST_GUARD_B;
          end else cnt <= cnt + CNT_W'(1);
        end
        ST_GUARD_B: begin
          if (cnt == guardS - CNT_W'(1)) begin
            cnt    <= '0;
            pixIdx <= '0;
            state  <= ST_PIXELS;
          end else cnt <= cnt + CNT_W'(1);
        end
        ST_PIXELS: begin
          if (cnt == perS - CNT_W'(1)) begin
            cnt <= '0;
            if (pixIdx == pixTotalS - PIXN_W'(1)) begin
              pixIdx <= '0;
              state  <= ST_IDLE;
            end else pixIdx <= pixIdx + PIXN_W'(1);
          end else cnt <= cnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic inPix;
  assign inPix = (state == ST_PIXELS);

  always_comb begin
    strobes.loadCfg = accept;
    strobes.trOn    = (state == ST_TRANSFER);
    strobes.rsOn    = inPix && (cnt == '0);
    strobes.phiHigh = inPix && !pixIdx[0];
    if (!inPix)                strobes.cls = CLS_NONE;
    else if (pixIdx < dumEndS) strobes.cls = CLS_DUMMY;
    else if (pixIdx < obEndS)  strobes.cls = CLS_OB;
    else                       strobes.cls = CLS_ACTIVE;
  end

  // R6: pixel index never passes the captured line length
  p_pix_bound_r6: assert property (@(posedge clk) disable iff (rst)
    inPix |-> (pixIdx < pixTotalS));

  // R9: a request during a running line leaves the captured settings alone
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && lineStart) |=>
      ($stable(pixTotalS) && $stable(perS) && $stable(trS) && $stable(guardS)));

endmodule

// File: rtl/ccd_drive_dp.sv
module ccd_drive_dp
  import ccd_timing_pkg::*;
#(
  parameter int MIN_TR = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  strobe_t    strobes,
  input  logic [3:0] enMask,
  input  logic [2:0] invMask,
  output logic       phi1,
  output logic       phi2,
  output logic       rsOut,
  output logic       trOut,
  output logic [1:0] pixClass
);

  localparam int RUN_W = $clog2(MIN_TR + 1);

  logic [3:0] enQ;
  logic [2:0] invQ;
  logic       trRawQ, rsRawQ;
  logic [RUN_W-1:0] trRun;

  // enables and polarity used for the next output cycle
  logic [3:0] enUse;
  logic [2:0] invUse;
  assign enUse  = (rst || strobes.loadCfg) ? enMask  : enQ;
  assign invUse = (rst || strobes.loadCfg) ? invMask : invQ;

  logic rawP1, rawP2, rawRs, rawTr;
  always_comb begin
    if (rst) begin
      rawP1 = 1'b0;
      rawP2 = 1'b1;
      rawRs = 1'b0;
      rawTr = 1'b0;
    end else begin
      rawP1 = strobes.phiHigh;
      rawP2 = !strobes.phiHigh;
      rawRs = strobes.rsOn;
      rawTr = strobes.trOn;
    end
  end

  always_ff @(posedge clk) begin
    enQ      <= enUse;
    invQ     <= invUse;
    phi1     <= (enUse[0] & rawP1) ^ invUse[0];
    phi2     <= (enUse[1] & rawP2) ^ invUse[0];
    rsOut    <= (enUse[2] & rawRs) ^ invUse[1];
    trOut    <= (enUse[3] & rawTr) ^ invUse[2];
    pixClass <= rst ? CLS_NONE : strobes.cls;
    rsRawQ   <= rawRs;
    trRawQ   <= rawTr;
    if (rst || !rawTr) trRun <= '0;
    else if (trRawQ && trRun != RUN_W'(MIN_TR)) trRun <= trRun + RUN_W'(1);
  end

  // R5: reset-gate pulse lasts a single cycle
  p_rs_single_r5: assert property (@(posedge clk) disable iff (rst)
    rsRawQ |=> !rsRawQ);

  // R2: a transfer pulse never ends before the minimum width
  p_tr_min_r2: assert property (@(posedge clk) disable iff (rst)
    (trRawQ && !strobes.trOn) |-> (trRun >= RUN_W'(MIN_TR - 1)));

  // R4: enabled shift clocks stay complementary on the pins
  p_phi_compl_r4: assert property (@(posedge clk) disable iff (rst)
    (enQ[0] && enQ[1]) |-> (phi1 != phi2));

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccd_timing_pkg::*;
#(
  parameter int TIME_W  = 8,
  parameter int PER_W   = 6,
  parameter int DUM_W   = 6,
  parameter int OB_W    = 6,
  parameter int ACT_W   = 10,
  parameter int MIN_TR  = 20,
  parameter int MIN_GRD = 20,
  parameter int MIN_PER = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lineStart,
  input  logic [3:0]        enMask,
  input  logic [2:0]        invMask,
  input  logic [TIME_W-1:0] trWidth,
  input  logic [TIME_W-1:0] guardLen,
  input  logic [PER_W-1:0]  pixPeriod,
  input  logic [DUM_W-1:0]  dummyReg,
  input  logic [OB_W-1:0]   obReg,
  input  logic [ACT_W-1:0]  activeCnt,
  output logic              phi1,
  output logic              phi2,
  output logic              rsOut,
  output logic              trOut,
  output logic [1:0]        pixClass
);

  strobe_t strobes;

  ccd_seq_ctrl #(
    .TIME_W(TIME_W), .PER_W(PER_W), .DUM_W(DUM_W), .OB_W(OB_W), .ACT_W(ACT_W),
    .MIN_TR(MIN_TR), .MIN_GRD(MIN_GRD), .MIN_PER(MIN_PER)
  ) u_ctrl (
    .clk(clk), .rst(rst), .lineStart(lineStart),
    .trWidth(trWidth), .guardLen(guardLen), .pixPeriod(pixPeriod),
    .dummyReg(dummyReg), .obReg(obReg), .activeCnt(activeCnt),
    .strobes(strobes)
  );

  ccd_drive_dp #(.MIN_TR(MIN_TR)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .enMask(enMask), .invMask(invMask),
    .phi1(phi1), .phi2(phi2), .rsOut(rsOut), .trOut(trOut),
    .pixClass(pixClass)
  );

endmodule

// File: tb/ccd_timing_gen_test.sv
`timescale 1ns/1ps
module ccd_timing_gen_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lineStart = 1'b0;
  logic [3:0] enMask = 4'hF;
  logic [2:0] invMask = 3'b000;
  logic [7:0] trWidth = 8'd5, guardLen = 8'd3;
  logic [5:0] pixPeriod = 6'd2, dummyReg = 6'd3, obReg = 6'd2;
  logic [9:0] activeCnt = 10'd3;
  logic phi1, phi2, rsOut, trOut;
  logic [1:0] pixClass;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ccd_timing_gen uut (
    .clk(clk), .rst(rst), .lineStart(lineStart), .enMask(enMask), .invMask(invMask),
    .trWidth(trWidth), .guardLen(guardLen), .pixPeriod(pixPeriod),
    .dummyReg(dummyReg), .obReg(obReg), .activeCnt(activeCnt),
    .phi1(phi1), .phi2(phi2), .rsOut(rsOut), .trOut(trOut), .pixClass(pixClass)
  );

  // expected {phi1,phi2,rs,tr,cls} for state cycle t under given settings
  function automatic logic [5:0] model(int t, logic [3:0] en, logic [2:0] inv,
      int tr, int gd, int per, int dm, int ob, int act);
    int g, w, p, d, b, n, u, k, cls;
    logic r1, r2, rr, rt;
    g = (gd < 20) ? 20 : gd;
    w = (tr < 20) ? 20 : tr;
    p = (per < 4) ? 4 : per;
    d = ((dm < 1) ? 1 : dm) - 1;
    b = (ob < 1) ? 1 : ob;
    n = d + b + act;
    r1 = 0; r2 = 1; rr = 0; rt = 0; cls = 0;
    if (t >= g && t < g + w) rt = 1;
    else if (t >= 2*g + w) begin
      u = t - (2*g + w);
      k = u / p;
      if (k < n) begin
        r1 = (k % 2 == 0);
        r2 = !r1;
        rr = (u % p == 0);
        cls = (k < d) ? 1 : (k < d + b) ? 2 : 3;
      end
    end
    return {(en[0] & r1) ^ inv[0], (en[1] & r2) ^ inv[0],
            (en[2] & rr) ^ inv[1], (en[3] & rt) ^ inv[2], 2'(cls)};
  endfunction

  task automatic check(string tag, int t, logic [5:0] exp);
    logic [5:0] got;
    string who;
    got = {phi1, phi2, rsOut, trOut, pixClass};
    checks++;
    if (got !== exp) begin
      fails++;
      if (got[1:0] !== exp[1:0])      who = "R6";
      else if (got[3] !== exp[3])     who = "R5";
      else if (got[2] !== exp[2])     who = "R2";
      else                            who = "R4";
      $display("FAIL %s/%s t=%0d got %b exp %b", tag, who, t, got, exp);
    end
  endtask

  // run a line; optionally at cycle midAt change every setting and raise a request
  task automatic run_line(string tag, int midAt);
    logic [3:0] en; logic [2:0] inv;
    int tr, gd, per, dm, ob, act, g, w, p, len;
    en = enMask; inv = invMask; tr = trWidth; gd = guardLen; per = pixPeriod;
    dm = dummyReg; ob = obReg; act = activeCnt;
    g = (gd < 20) ? 20 : gd; w = (tr < 20) ? 20 : tr; p = (per < 4) ? 4 : per;
    len = 2*g + w + p * (((dm < 1) ? 0 : dm - 1) + ((ob < 1) ? 1 : ob) + act);
    @(negedge clk); lineStart = 1'b1;
    @(posedge clk); #1 lineStart = 1'b0;
    for (int n = 1; n <= len + 2; n++) begin
      @(posedge clk); #1;
      check(tag, n - 1, model(n - 1, en, inv, tr, gd, per, dm, ob, act));
      if (n == midAt) begin
        lineStart = 1'b1; enMask = 4'b1010; invMask = 3'b111; trWidth = 8'd30;
        guardLen = 8'd25; pixPeriod = 6'd6; dummyReg = 6'd2; obReg = 6'd1; activeCnt = 10'd2;
      end else lineStart = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset gives idle levels under live settings
    check("R10", -1, model(-1, enMask, invMask, 5, 3, 2, 3, 2, 3));
    @(negedge clk); rst = 1'b0;
    // R1 R2 R3 R4 R5 R6: clamped minima, short period, all enabled
    run_line("R1", 0);
    // R8: all inverted, no dummies, clamped ob, longer settings
    trWidth = 8'd25; guardLen = 8'd22; pixPeriod = 6'd5; dummyReg = 6'd0; obReg = 6'd0;
    activeCnt = 10'd4; invMask = 3'b111;
    run_line("R8", 0);
    // R7: partial enables, rs inverted, no active pixels
    enMask = 4'b0101; invMask = 3'b010; dummyReg = 6'd1; obReg = 6'd3; activeCnt = 10'd0;
    pixPeriod = 6'd4;
    run_line("R7", 0);
    // R9: mid-line request and setting change ignored, then used on next line
    enMask = 4'hF; invMask = 3'b000; trWidth = 8'd21; guardLen = 8'd20; pixPeriod = 6'd4;
    dummyReg = 6'd4; obReg = 6'd2; activeCnt = 10'd5;
    run_line("R9", 30);
    run_line("R9", 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got %0d cycles exp completion", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule